// File: doc/BRIEF.md
# PLL Lock Status Tracker with Output Clock Gate

This block decides when a phase-locked loop may be considered locked and keeps the loop's output clock switched off until it is. It samples a raw lock-detect level from the analog loop on the reference clock. It reports a single status bit, 1 meaning locked. A status of 1 is granted only after the raw level has stayed high for a programmable run of consecutive reference cycles.

Several events throw the tracker back to the unlocked state at once:
- software writes a new value into the reference-divider or VCO-multiplier field;
- the chip enters a stop mode while the keep-running-in-stop bit is clear;
- the loop is disabled.

After any such event the raw indication is disregarded for a short blanking window, so a stale high level cannot bring the status straight back. A clock enable follows the status on the falling edge of the PLL clock. That enable is ANDed with the PLL clock to give a gated output without runt pulses.

Top module: `pll_lock_gate`

## Requirements
- R1: The clock enable `pll_clk_en` is 0 whenever `lock_st` is 0. It takes the value of `lock_st` at the next falling edge of `pll_clk`.
- R2: A write to the reference-divider field (`refdiv_wr`=1) whose data differs from the stored field value clears `lock_st` at that clock edge. A write of the stored value leaves `lock_st` unchanged. The stored value resets to 0.
- R3: A write to the VCO-multiplier field (`vcomul_wr`=1) behaves in the same way: differing data clears `lock_st`, equal data does nothing. The stored value resets to 0.
- R4: While `stop_mode`=1 with `pll_stop_en`=0, `lock_st` is cleared and held at 0 for the whole stop period. While `stop_mode`=1 with `pll_stop_en`=1, the status is unaffected.
- R5: `lock_st`=1 means locked and 0 means unlocked. Outside blanking, `lock_st` becomes 1 at the edge that samples the LOCK_CNT-th consecutive high value of `lock_raw` (default 16).
- R6: Any low sample of `lock_raw` restarts the consecutive count. If it occurs while locked, it clears `lock_st` at that edge.
- R7: After reset or a forced clear (R2, R3, R4, R9), the next BLANK_CYC edges (default 2) ignore `lock_raw`. With the raw level held high throughout, `lock_st` therefore rises BLANK_CYC+LOCK_CNT edges after the clearing edge.
- R8: During reset, `lock_st` and `pll_clk_en` are both 0.
- R9: While `pll_en`=0, `lock_st` is 0 from the next edge on, whatever `lock_raw` does.
- R10: `pll_clk_gated` equals `pll_clk` while `pll_clk_en` is 1 and stays 0 while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that samples the lock detector and control events |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_en | input | 1 | PLL enable |
| lock_raw | input | 1 | Raw lock-detect level from the analog loop |
| refdiv_wr | input | 1 | Write strobe of the reference-divider field |
| refdiv_wdata | input | DIV_W | Data written to the reference-divider field |
| vcomul_wr | input | 1 | Write strobe of the VCO-multiplier field |
| vcomul_wdata | input | MUL_W | Data written to the VCO-multiplier field |
| stop_mode | input | 1 | High while the chip is in a stop or low-leakage stop mode |
| pll_stop_en | input | 1 | Keep the PLL running during stop |
| pll_clk | input | 1 | PLL output clock to be gated |
| lock_st | output | 1 | Lock status, 1 = locked |
| pll_clk_en | output | 1 | Gate enable, registered on the falling edge of pll_clk |
| pll_clk_gated | output | 1 | Gated PLL clock |

## Verification
The hardest case to reach is a run of LOCK_CNT unbroken high raw samples that ends exactly at the edge where a clearing event, a blanking window or a single low sample arrives. Random traffic seldom lines these up. Directed sequences therefore hold the raw level high from a known clearing edge and check the status one edge before and at the exact edge where it must rise. They also inject same-value and different-value field writes, and stop periods with the keep-running bit both set and clear, into an already locked tracker. Long constrained-random runs with rare low samples, rare writes and rare stop or disable periods then compare every cycle against a bench model.

// File: rtl/pllt_pkg.sv
package pllt_pkg;
   typedef enum logic [1:0] {
      PH_BLANK = 2'd0,
      PH_ACQ   = 2'd1,
      PH_LOCK  = 2'd2
   } pllt_phase_e;

   function automatic int pllt_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/pllt_field_watch.sv
module pllt_field_watch #(
   parameter int W        = 5,
   parameter bit CMP_DIFF = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic         chg
);
   logic [W-1:0] shadow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  shadow_q <= '0;
      else if (wr) shadow_q <= wdata;
   end

   generate
      if (CMP_DIFF) begin : g_diff
         assign chg = wr && (wdata != shadow_q);
      end else begin : g_any
         assign chg = wr;
      end
   endgenerate
endmodule

// File: rtl/pllt_lock_fsm.sv
module pllt_lock_fsm
   import pllt_pkg::*;
#(
   parameter int LOCK_CNT  = 16,
   parameter int BLANK_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic lock_raw,
   output logic locked
);
   localparam int CMAX = pllt_max(LOCK_CNT, BLANK_CYC);
   localparam int CW   = $clog2(CMAX + 1);
   localparam logic [CW-1:0] LOCK_LAST  = CW'(LOCK_CNT - 1);
   localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_CYC - 1);

   pllt_phase_e   phase_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_BLANK;
         cnt_q   <= BLANK_LAST;
      end else if (hold) begin
         phase_q <= PH_BLANK;
         cnt_q   <= BLANK_LAST;
      end else begin
         unique case (phase_q)
            PH_BLANK: begin
               if (cnt_q == '0) phase_q <= PH_ACQ;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            PH_ACQ: begin
               if (!lock_raw) begin
                  cnt_q <= '0;
               end else if (cnt_q == LOCK_LAST) begin
                  phase_q <= PH_LOCK;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_LOCK: begin
               if (!lock_raw) begin
                  phase_q <= PH_ACQ;
                  cnt_q   <= '0;
               end
            end
            default: begin
               phase_q <= PH_BLANK;
               cnt_q   <= BLANK_LAST;
            end
         endcase
      end
   end

   assign locked = (phase_q == PH_LOCK);
endmodule

// File: rtl/pllt_clk_gate.sv
module pllt_clk_gate (
   input  logic pll_clk,
   input  logic rst_n,
   input  logic en_req,
   output logic en,
   output logic gated
);
   logic en_q;

   always_ff @(negedge pll_clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en_req;
   end

   assign en    = en_q;
   assign gated = pll_clk & en_q;
endmodule

// File: rtl/pll_lock_gate.sv
module pll_lock_gate #(
   parameter int DIV_W     = 5,
   parameter int MUL_W     = 5,
   parameter int LOCK_CNT  = 16,
   parameter int BLANK_CYC = 2,
   parameter bit CMP_DIFF  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pll_en,
   input  logic             lock_raw,
   input  logic             refdiv_wr,
   input  logic [DIV_W-1:0] refdiv_wdata,
   input  logic             vcomul_wr,
   input  logic [MUL_W-1:0] vcomul_wdata,
   input  logic             stop_mode,
   input  logic             pll_stop_en,
   input  logic             pll_clk,
   output logic             lock_st,
   output logic             pll_clk_en,
   output logic             pll_clk_gated
);
   generate
      if (DIV_W < 1 || MUL_W < 1) begin : g_bad_w
         $error("field widths must be at least 1");
      end
      if (LOCK_CNT < 1) begin : g_bad_cnt
         $error("LOCK_CNT must be at least 1");
      end
      if (BLANK_CYC < 1) begin : g_bad_blank
         $error("BLANK_CYC must be at least 1");
      end
   endgenerate

   logic ref_chg;
   logic mul_chg;
   logic stop_kill;
   logic hold;

   pllt_field_watch #(.W(DIV_W), .CMP_DIFF(CMP_DIFF)) u_ref (
      .clk(clk), .rst_n(rst_n), .wr(refdiv_wr), .wdata(refdiv_wdata), .chg(ref_chg)
   );

   pllt_field_watch #(.W(MUL_W), .CMP_DIFF(CMP_DIFF)) u_mul (
      .clk(clk), .rst_n(rst_n), .wr(vcomul_wr), .wdata(vcomul_wdata), .chg(mul_chg)
   );

   assign stop_kill = stop_mode & ~pll_stop_en;
   assign hold      = ~pll_en | stop_kill | ref_chg | mul_chg;

   pllt_lock_fsm #(.LOCK_CNT(LOCK_CNT), .BLANK_CYC(BLANK_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .hold(hold), .lock_raw(lock_raw), .locked(lock_st)
   );

   pllt_clk_gate u_gate (
      .pll_clk(pll_clk), .rst_n(rst_n), .en_req(lock_st),
      .en(pll_clk_en), .gated(pll_clk_gated)
   );
endmodule

// File: rtl/pll_lock_gate_chk.sv
module pll_lock_gate_chk #(
   parameter int DIV_W = 5,
   parameter int MUL_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pll_en,
   input logic             lock_raw,
   input logic             stop_mode,
   input logic             pll_stop_en,
   input logic             pll_clk,
   input logic             ref_chg,
   input logic             mul_chg,
   input logic             lock_st,
   input logic             pll_clk_en
);
   p_gate_low_r1: assert property (@(negedge pll_clk) disable iff (!rst_n)
      !lock_st |=> !pll_clk_en);

   p_refdiv_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ref_chg |=> !lock_st);

   p_vcomul_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mul_chg |=> !lock_st);

   p_stop_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_mode && !pll_stop_en) |=> !lock_st);

   p_rise_on_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_st) |-> $past(lock_raw));

   p_raw_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_raw |=> !lock_st);

   p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_en |=> !lock_st);
endmodule

bind pll_lock_gate pll_lock_gate_chk #(.DIV_W(DIV_W), .MUL_W(MUL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .lock_raw(lock_raw),
   .stop_mode(stop_mode), .pll_stop_en(pll_stop_en), .pll_clk(pll_clk),
   .ref_chg(ref_chg), .mul_chg(mul_chg), .lock_st(lock_st), .pll_clk_en(pll_clk_en)
);

// File: tb/tb_pll_lock_gate.sv
`timescale 1ns/1ps
module tb_pll_lock_gate;
   localparam int DW = 5;
   localparam int MW = 5;
   localparam int LC = 16;
   localparam int BC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pll_en = 1'b0, lock_raw = 1'b0, refdiv_wr = 1'b0, vcomul_wr = 1'b0;
   logic stop_mode = 1'b0, pll_stop_en = 1'b0;
   logic [DW-1:0] refdiv_wdata = '0;
   logic [MW-1:0] vcomul_wdata = '0;
   logic lock_st, pll_clk_en, pll_clk_gated;

   int n_chk = 0, n_fail = 0, cycles = 0;
   bit done = 1'b0, live = 1'b0;

   always #5 clk = ~clk;

   pll_lock_gate #(.DIV_W(DW), .MUL_W(MW), .LOCK_CNT(LC), .BLANK_CYC(BC)) dut (
      .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .lock_raw(lock_raw),
      .refdiv_wr(refdiv_wr), .refdiv_wdata(refdiv_wdata),
      .vcomul_wr(vcomul_wr), .vcomul_wdata(vcomul_wdata),
      .stop_mode(stop_mode), .pll_stop_en(pll_stop_en), .pll_clk(clk),
      .lock_st(lock_st), .pll_clk_en(pll_clk_en), .pll_clk_gated(pll_clk_gated)
   );

   // Bench model built from the requirements
   bit m_lock, m_en;
   int m_run, m_skip;
   logic [DW-1:0] m_ref;
   logic [MW-1:0] m_mul;

   function automatic bit clears(input bit en, input bit st, input bit pse,
                                 input bit rw, input bit rd_diff,
                                 input bit mw, input bit md_diff);
      return !en || (st && !pse) || (rw && rd_diff) || (mw && md_diff);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lock <= 1'b0; m_en <= 1'b0; m_run <= 0; m_skip <= BC;
         m_ref <= '0; m_mul <= '0;
      end else begin
         m_en <= m_lock;
         if (refdiv_wr) m_ref <= refdiv_wdata;
         if (vcomul_wr) m_mul <= vcomul_wdata;
         if (clears(pll_en, stop_mode, pll_stop_en, refdiv_wr, refdiv_wdata != m_ref,
                    vcomul_wr, vcomul_wdata != m_mul)) begin
            m_lock <= 1'b0; m_run <= 0; m_skip <= BC;
         end else if (m_skip > 0) begin
            m_skip <= m_skip - 1;
         end else if (!lock_raw) begin
            m_lock <= 1'b0; m_run <= 0;
         end else begin
            m_run <= m_run + 1;
            if (m_run + 1 >= LC) m_lock <= 1'b1;
         end
      end
   end

   task automatic check(input logic act, input logic exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the edges
   always @(posedge clk) begin
      #4;
      if (live && rst_n) begin
         check(lock_st, m_lock, "R5 lock status");
         check(pll_clk_en, m_en, "R1 clock enable");
         check(pll_clk_gated, m_en, "R10 gated clock high phase");
      end
   end
   always @(negedge clk) begin
      #4;
      if (live && rst_n) check(pll_clk_gated, 1'b0, "R10 gated clock low phase");
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000 && !done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected finish");
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   initial begin
      void'($urandom(32'd2718));
      tick(3);
      check(lock_st, 1'b0, "R8 reset status");
      check(pll_clk_en, 1'b0, "R8 reset enable");
      pll_en = 1'b1; lock_raw = 1'b1;
      rst_n = 1'b1; live = 1'b1;
      // R7 blank then R5 count from reset release
      tick(BC + LC - 1);
      check(lock_st, 1'b0, "R7 one edge before lock");
      tick(1);
      check(lock_st, 1'b1, "R5 lock after full run");
      // R2 same-value write, then differing write
      refdiv_wr = 1'b1; refdiv_wdata = '0; tick(1); refdiv_wr = 1'b0;
      check(lock_st, 1'b1, "R2 same divider value keeps lock");
      refdiv_wr = 1'b1; refdiv_wdata = 5'd5; tick(1); refdiv_wr = 1'b0;
      check(lock_st, 1'b0, "R2 new divider value clears");
      tick(BC + LC - 1);
      check(lock_st, 1'b0, "R7 stale high ignored during blank");
      tick(1);
      check(lock_st, 1'b1, "R7 relock after blank and run");
      // R3
      vcomul_wr = 1'b1; vcomul_wdata = '0; tick(1); vcomul_wr = 1'b0;
      check(lock_st, 1'b1, "R3 same multiplier value keeps lock");
      vcomul_wr = 1'b1; vcomul_wdata = 5'd9; tick(1); vcomul_wr = 1'b0;
      check(lock_st, 1'b0, "R3 new multiplier value clears");
      tick(BC + LC);
      check(lock_st, 1'b1, "R3 relock");
      // R4 stop with and without keep-running
      pll_stop_en = 1'b1; stop_mode = 1'b1; tick(10);
      check(lock_st, 1'b1, "R4 stop with keep-running bit");
      stop_mode = 1'b0; tick(1);
      pll_stop_en = 1'b0; stop_mode = 1'b1; tick(1);
      check(lock_st, 1'b0, "R4 stop clears");
      tick(30);
      check(lock_st, 1'b0, "R4 held during stop");
      stop_mode = 1'b0; tick(BC + LC);
      check(lock_st, 1'b1, "R4 relock after exit");
      // R6 single low sample
      lock_raw = 1'b0; tick(1); lock_raw = 1'b1;
      check(lock_st, 1'b0, "R6 low sample unlocks");
      tick(LC - 1);
      check(lock_st, 1'b0, "R6 count restarted");
      tick(1);
      check(lock_st, 1'b1, "R6 relock without blank");
      // R9 disable
      pll_en = 1'b0; tick(1);
      check(lock_st, 1'b0, "R9 disable clears");
      tick(1);
      check(pll_clk_en, 1'b0, "R1 enable low when disabled");
      tick(40);
      check(lock_st, 1'b0, "R9 raw high ignored while disabled");
      pll_en = 1'b1;
      // constrained random phase
      for (int i = 0; i < 15000; i++) begin
         lock_raw  = ($urandom % 60) != 0;
         refdiv_wr = ($urandom % 90) == 0;
         refdiv_wdata = ($urandom % 2) ? m_ref : DW'($urandom);
         vcomul_wr = ($urandom % 90) == 0;
         vcomul_wdata = ($urandom % 2) ? m_mul : MW'($urandom);
         if (!stop_mode && ($urandom % 300) == 0) begin
            stop_mode = 1'b1; pll_stop_en = $urandom % 2;
         end else if (stop_mode && ($urandom % 20) == 0) begin
            stop_mode = 1'b0;
         end
         if (pll_en && ($urandom % 700) == 0) pll_en = 1'b0;
         else if (!pll_en && ($urandom % 15) == 0) pll_en = 1'b1;
         tick(1);
      end
      tick(2);
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule